// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block keeps the tag state of one cache level: tags, valid bits, dirty bits and a replacement order for each set. There is no data array. Each request carries an address, a write flag and a prefetch flag. The block decides whether the request hits or misses and updates the set state at the same clock edge. One cycle later it returns a registered hit/miss response.

Replacement order is set by a parameter. In least-recently-used mode a hit moves the way to the front of the order. In first-in-first-out mode the order changes only when a line is filled. The write policy is also a parameter:

- **Write-back:** a write marks the line dirty, and a dirty victim is counted when it is evicted.
- **Write-through:** every write, hit or miss, is counted.

Demand traffic and prefetch traffic are counted in separate counters. A demand hit rate can therefore be formed as demand hits over the sum of demand hits and demand misses, with no prefetch traffic in it. All counters saturate. A synchronous clear zeroes the counters and leaves the tag state alone.

Top module: `sa_tag_ctrl`

## Requirements
- R1: The set count is CACHE_BYTES/(LINE_BYTES*WAYS), and LINE_BYTES and the set count are powers of two. The set index is addr >> log2(LINE_BYTES), masked to log2(sets) bits. The tag is addr >> (log2(LINE_BYTES)+log2(sets)). Offset bits have no effect on the lookup.
- R2: req_ready is high in every cycle after the first clock edge with rst low. A request with req_valid and req_ready high produces rsp_valid high, with rsp_hit, in the next cycle. rsp_valid is low in a cycle that follows a cycle with no accepted request.
- R3: On a miss, the lowest-numbered invalid way of the set is filled. If the set has no invalid way, the way that is oldest in replacement order is evicted.
- R4: With REPL = REPL_LRU, a hit makes the way the newest. With REPL = REPL_FIFO, a hit leaves the order unchanged.
- R5: A write hit sets the line's dirty bit under WPOL_BACK. Under WPOL_THROUGH it increments cnt_wt instead.
- R6: A filled line is dirty only when the request is a write under WPOL_BACK. A write miss under WPOL_THROUGH increments cnt_wt.
- R7: Evicting a dirty line under WPOL_BACK increments both cnt_wb and cnt_dirty_ev. Under WPOL_THROUGH neither counter moves.
- R8: Each accepted request adds one to exactly one of four counters: cnt_pf_hit or cnt_pf_miss when req_prefetch is set, otherwise cnt_dmd_hit or cnt_dmd_miss. The update is visible in the same cycle as the response.
- R9: Every counter stops at all ones (2^CNT_W-1) and never wraps.
- R10: clr high at a clock edge zeroes all counters and keeps tags, valid bits and dirty bits.
- R11: rst invalidates every way, clears every dirty bit and zeroes every counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous counter clear |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | Request is a write |
| req_prefetch | input | 1 | Request is a prefetch |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_hit | output | 1 | Response was a hit |
| cnt_dmd_hit | output | CNT_W | Demand hits |
| cnt_dmd_miss | output | CNT_W | Demand misses |
| cnt_pf_hit | output | CNT_W | Prefetch hits |
| cnt_pf_miss | output | CNT_W | Prefetch misses |
| cnt_wb | output | CNT_W | Write-backs |
| cnt_dirty_ev | output | CNT_W | Dirty evictions |
| cnt_wt | output | CNT_W | Write-through writes |

## Verification
A corrupted replacement order does not show at once. It shows only when a set is full and the next miss evicts the wrong way; the following access to the line that should have survived then reports a miss. The bench therefore fills two-way sets and re-touches lines in orders that give different answers under each policy.

A lost or stray dirty bit shows later still, in cnt_wb and cnt_dirty_ev at the eviction of that line. For this reason every write-back scenario runs until the written line is pushed out. Errors in counter routing or in the decode show in the counter outputs in the same cycle as the response.

// File: rtl/sa_tag_pkg.sv
package sa_tag_pkg;
  typedef enum logic { REPL_FIFO = 1'b0, REPL_LRU = 1'b1 } repl_e;
  typedef enum logic { WPOL_THROUGH = 1'b0, WPOL_BACK = 1'b1 } wpol_e;

  localparam int unsigned CNT_DMD_HIT  = 0;
  localparam int unsigned CNT_DMD_MISS = 1;
  localparam int unsigned CNT_PF_HIT   = 2;
  localparam int unsigned CNT_PF_MISS  = 3;
  localparam int unsigned CNT_WB       = 4;
  localparam int unsigned CNT_DIRTY_EV = 5;
  localparam int unsigned CNT_WT       = 6;
  localparam int unsigned NUM_CNT      = 7;
endpackage

// File: rtl/sa_set_lookup.sv
module sa_set_lookup #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 24,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);
  logic [WAYS-1:0] match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tags_i[g] == tag_i);
  end

  assign hit_o = |match;

  always_comb begin
    way_o = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (match[i]) way_o = WAY_W'(i);
    end
  end
endmodule

// File: rtl/sa_victim_pick.sv
module sa_victim_pick #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][WAY_W-1:0] rank_i,
  output logic [WAY_W-1:0]           way_o
);
  always_comb begin
    way_o = '0;
    if (&valid_i) begin
      for (int i = 0; i < WAYS; i++) begin
        if (rank_i[i] == WAY_W'(WAYS - 1)) way_o = WAY_W'(i);
      end
    end else begin
      for (int i = WAYS - 1; i >= 0; i--) begin
        if (!valid_i[i]) way_o = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/sa_order_update.sv
module sa_order_update #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][WAY_W-1:0] rank_i,
  input  logic [WAY_W-1:0]           sel_i,
  output logic [WAYS-1:0][WAY_W-1:0] rank_o
);
  logic [WAY_W-1:0] sel_rank;
  assign sel_rank = rank_i[sel_i];

  for (genvar g = 0; g < WAYS; g++) begin : g_rank
    always_comb begin
      if (WAY_W'(g) == sel_i)          rank_o[g] = '0;
      else if (rank_i[g] < sel_rank)   rank_o[g] = rank_i[g] + WAY_W'(1);
      else                             rank_o[g] = rank_i[g];
    end
  end
endmodule

// File: rtl/sa_sat_counter.sv
module sa_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr_i)                  count_o <= '0;
    else if (inc_i && count_o != MAX)  count_o <= count_o + W'(1);
  end

  // R9: a full counter stays full unless cleared
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (count_o == MAX && !clr_i) |=> (count_o == MAX));
  // R10: clear zeroes the counter at the next edge
  a_r10_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (count_o == '0));
endmodule

// File: rtl/sa_tag_ctrl.sv
module sa_tag_ctrl #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CACHE_BYTES = 4096,
  parameter int unsigned LINE_BYTES  = 64,
  parameter int unsigned WAYS        = 4,
  parameter sa_tag_pkg::repl_e REPL  = sa_tag_pkg::REPL_LRU,
  parameter sa_tag_pkg::wpol_e WPOL  = sa_tag_pkg::WPOL_BACK,
  parameter int unsigned CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_prefetch,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [CNT_W-1:0]  cnt_dmd_hit,
  output logic [CNT_W-1:0]  cnt_dmd_miss,
  output logic [CNT_W-1:0]  cnt_pf_hit,
  output logic [CNT_W-1:0]  cnt_pf_miss,
  output logic [CNT_W-1:0]  cnt_wb,
  output logic [CNT_W-1:0]  cnt_dirty_ev,
  output logic [CNT_W-1:0]  cnt_wt
);
  import sa_tag_pkg::*;

  localparam int unsigned SETS     = CACHE_BYTES / (LINE_BYTES * WAYS);
  localparam int unsigned OFF_W    = $clog2(LINE_BYTES);
  localparam int unsigned IDX_BITS = $clog2(SETS);
  localparam int unsigned IDX_W    = (IDX_BITS > 0) ? IDX_BITS : 1;
  localparam int unsigned TAG_W    = ADDR_W - OFF_W - IDX_BITS;
  localparam int unsigned WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam bit          IS_LRU   = (REPL == REPL_LRU);
  localparam bit          IS_WB    = (WPOL == WPOL_BACK);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Set state: tags without reset (RAM-friendly), control bits with reset
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAYS-1:0]            dirty_q [SETS];
  logic [WAYS-1:0][WAY_W-1:0] rank_q  [SETS];

  logic              rdy_q;
  logic              accept;
  logic [IDX_W-1:0]  set_idx;
  logic [TAG_W-1:0]  req_tag;
  logic              hit;
  logic [WAY_W-1:0]  hit_way, vic_way, fill_way;
  logic              vic_dirty, touch;
  logic [WAYS-1:0][WAY_W-1:0] new_rank;
  logic [NUM_CNT-1:0]         inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;

  assign req_ready = rdy_q;
  assign accept    = req_valid && rdy_q;
  assign set_idx   = IDX_W'((req_addr >> OFF_W) & ADDR_W'(SETS - 1));
  assign req_tag   = TAG_W'(req_addr >> (OFF_W + IDX_BITS));

  sa_set_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
    .tags_i (tag_q[set_idx]),
    .valid_i(valid_q[set_idx]),
    .tag_i  (req_tag),
    .hit_o  (hit),
    .way_o  (hit_way)
  );

  sa_victim_pick #(.WAYS(WAYS)) u_victim (
    .valid_i(valid_q[set_idx]),
    .rank_i (rank_q[set_idx]),
    .way_o  (vic_way)
  );

  assign fill_way  = hit ? hit_way : vic_way;
  assign vic_dirty = !hit && (&valid_q[set_idx]) && dirty_q[set_idx][vic_way];
  assign touch     = hit ? IS_LRU : 1'b1;

  sa_order_update #(.WAYS(WAYS)) u_order (
    .rank_i(rank_q[set_idx]),
    .sel_i (fill_way),
    .rank_o(new_rank)
  );

  always_comb begin
    inc               = '0;
    inc[CNT_DMD_HIT]  = accept &&  hit && !req_prefetch;
    inc[CNT_DMD_MISS] = accept && !hit && !req_prefetch;
    inc[CNT_PF_HIT]   = accept &&  hit &&  req_prefetch;
    inc[CNT_PF_MISS]  = accept && !hit &&  req_prefetch;
    inc[CNT_WB]       = accept && IS_WB && vic_dirty;
    inc[CNT_DIRTY_EV] = accept && IS_WB && vic_dirty;
    inc[CNT_WT]       = accept && !IS_WB && req_write;
  end

  always_ff @(posedge clk) begin
    if (accept && !hit) tag_q[set_idx][vic_way] <= req_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) rank_q[s][w] <= WAY_W'(w);
      end
    end else begin
      rdy_q     <= 1'b1;
      rsp_valid <= accept;
      if (accept) begin
        rsp_hit                    <= hit;
        valid_q[set_idx][fill_way] <= 1'b1;
        if (hit) begin
          if (req_write && IS_WB) dirty_q[set_idx][fill_way] <= 1'b1;
        end else begin
          dirty_q[set_idx][fill_way] <= req_write && IS_WB;
        end
        if (touch) rank_q[set_idx] <= new_rank;
      end
    end
  end

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    sa_sat_counter #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .clr_i  (clr),
      .inc_i  (inc[c]),
      .count_o(cnt[c])
    );
  end

  assign cnt_dmd_hit  = cnt[CNT_DMD_HIT];
  assign cnt_dmd_miss = cnt[CNT_DMD_MISS];
  assign cnt_pf_hit   = cnt[CNT_PF_HIT];
  assign cnt_pf_miss  = cnt[CNT_PF_MISS];
  assign cnt_wb       = cnt[CNT_WB];
  assign cnt_dirty_ev = cnt[CNT_DIRTY_EV];
  assign cnt_wt       = cnt[CNT_WT];

  // R2: an accepted request yields a response one cycle later
  a_r2_rsp_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);
  // R2: no response without an accepted request
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid);
  // R5/R6: under write-through every accepted write advances cnt_wt by one
  a_r5_wt_counts: assert property (@(posedge clk) disable iff (rst)
    (accept && req_write && !IS_WB && !clr && cnt_wt != CNT_MAX)
      |=> (cnt_wt == $past(cnt_wt) + CNT_W'(1)));
endmodule

// File: tb/test_sa_tag_ctrl.sv
module test_sa_tag_ctrl;
  import sa_tag_pkg::*;

  localparam int unsigned AW = 16;
  localparam int unsigned CW = 8;
  localparam realtime HALF = 2.5ns;

  logic clk = 1'b0, rst = 1'b1, clr = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_prefetch = 1'b0;
  logic [AW-1:0] req_addr = '0;

  logic lb_ready, lb_rv, lb_hit, ft_ready, ft_rv, ft_hit;
  logic [CW-1:0] lb_dh, lb_dm, lb_ph, lb_pm, lb_wb, lb_de, lb_wt;
  logic [CW-1:0] ft_dh, ft_dm, ft_ph, ft_pm, ft_wb, ft_de, ft_wt;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #HALF clk = ~clk;

  // LRU / write-back, 4 sets x 2 ways, 16-byte lines
  sa_tag_ctrl #(.ADDR_W(AW), .CACHE_BYTES(128), .LINE_BYTES(16), .WAYS(2),
    .REPL(REPL_LRU), .WPOL(WPOL_BACK), .CNT_W(CW)) i_sa_tag_ctrl (
    .clk, .rst, .clr, .req_valid, .req_ready(lb_ready), .req_addr, .req_write,
    .req_prefetch, .rsp_valid(lb_rv), .rsp_hit(lb_hit),
    .cnt_dmd_hit(lb_dh), .cnt_dmd_miss(lb_dm), .cnt_pf_hit(lb_ph),
    .cnt_pf_miss(lb_pm), .cnt_wb(lb_wb), .cnt_dirty_ev(lb_de), .cnt_wt(lb_wt));

  // FIFO / write-through, same geometry
  sa_tag_ctrl #(.ADDR_W(AW), .CACHE_BYTES(128), .LINE_BYTES(16), .WAYS(2),
    .REPL(REPL_FIFO), .WPOL(WPOL_THROUGH), .CNT_W(CW)) i_sa_tag_ctrl_ft (
    .clk, .rst, .clr, .req_valid, .req_ready(ft_ready), .req_addr, .req_write,
    .req_prefetch, .rsp_valid(ft_rv), .rsp_hit(ft_hit),
    .cnt_dmd_hit(ft_dh), .cnt_dmd_miss(ft_dm), .cnt_pf_hit(ft_ph),
    .cnt_pf_miss(ft_pm), .cnt_wb(ft_wb), .cnt_dirty_ev(ft_de), .cnt_wt(ft_wt));

  // address: tag * 64 + set * 16 + byte offset
  function automatic logic [AW-1:0] adr(int tag, int set, int off = 0);
    return AW'(tag * 64 + set * 16 + off);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0; clr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [AW-1:0] a, input logic wr, input logic pf,
                      output logic h_lb, output logic h_ft);
    req_addr = a; req_write = wr; req_prefetch = pf; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 lb rsp_valid", int'(lb_rv), 1);
    chk("R2 ft rsp_valid", int'(ft_rv), 1);
    h_lb = lb_hit; h_ft = ft_hit;
  endtask

  task automatic t_reset();
    logic a, b;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R2 ready low in reset", int'(lb_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 ready after reset", int'(lb_ready), 1);
    chk("R11 lb counters zero", int'(lb_dh + lb_dm + lb_ph + lb_pm + lb_wb + lb_de + lb_wt), 0);
    chk("R11 ft counters zero", int'(ft_dh + ft_dm + ft_ph + ft_pm + ft_wb + ft_de + ft_wt), 0);
    chk("R2 no rsp when idle", int'(lb_rv), 0);
    send(adr(1, 0), 1'b0, 1'b0, a, b);
    do_reset();
    send(adr(1, 0), 1'b0, 1'b0, a, b);
    chk("R11 lb invalid after reset", int'(a), 0);
    chk("R11 ft invalid after reset", int'(b), 0);
  endtask

  task automatic t_basic();
    logic a, b;
    do_reset();
    send(adr(1, 0, 3), 1'b0, 1'b0, a, b);
    chk("R8 cold miss", int'(a), 0);
    send(adr(1, 0, 12), 1'b0, 1'b0, a, b);
    chk("R1 offset ignored lb", int'(a), 1);
    chk("R1 offset ignored ft", int'(b), 1);
    chk("R8 dmd hit", int'(lb_dh), 1);
    chk("R8 dmd miss", int'(lb_dm), 1);
    @(negedge clk);
    chk("R2 no rsp after idle", int'(lb_rv), 0);
    chk("R8 idle keeps count", int'(lb_dh), 1);
  endtask

  task automatic t_sets();
    logic a, b;
    do_reset();
    send(adr(5, 0), 1'b0, 1'b0, a, b);
    send(adr(6, 0), 1'b0, 1'b0, a, b);
    send(adr(5, 1), 1'b0, 1'b0, a, b);
    send(adr(6, 1), 1'b0, 1'b0, a, b);
    chk("R3 fills use free ways", int'(lb_dm), 4);
    send(adr(5, 0), 1'b0, 1'b0, a, b); chk("R1 set0 tag5", int'(a & b), 1);
    send(adr(6, 0), 1'b0, 1'b0, a, b); chk("R1 set0 tag6", int'(a & b), 1);
    send(adr(5, 1), 1'b0, 1'b0, a, b); chk("R1 set1 tag5", int'(a & b), 1);
    send(adr(6, 1), 1'b0, 1'b0, a, b); chk("R1 set1 tag6", int'(a & b), 1);
  endtask

  task automatic t_repl();
    logic a, b;
    do_reset();
    send(adr(1, 2), 1'b0, 1'b0, a, b);
    send(adr(2, 2), 1'b0, 1'b0, a, b);
    send(adr(1, 2), 1'b0, 1'b0, a, b);
    chk("R4 hit before evict", int'(a & b), 1);
    send(adr(3, 2), 1'b0, 1'b0, a, b);
    send(adr(1, 2), 1'b0, 1'b0, a, b);
    chk("R4 LRU keeps promoted line", int'(a), 1);
    chk("R3 FIFO evicts oldest fill", int'(b), 0);
    send(adr(2, 2), 1'b0, 1'b0, a, b);
    chk("R3 LRU evicted lru line", int'(a), 0);
    chk("R3 FIFO evicted second fill", int'(b), 0);
  endtask

  task automatic t_write();
    logic a, b;
    do_reset();
    send(adr(1, 3), 1'b1, 1'b0, a, b);
    chk("R6 wt write miss", int'(ft_wt), 1);
    send(adr(2, 3), 1'b0, 1'b0, a, b);
    send(adr(3, 3), 1'b0, 1'b0, a, b);
    chk("R7 lb dirty victim wb", int'(lb_wb), 1);
    chk("R7 lb dirty victim de", int'(lb_de), 1);
    chk("R7 ft never wb", int'(ft_wb), 0);
    send(adr(2, 3), 1'b1, 1'b0, a, b);
    chk("R5 write hit", int'(a & b), 1);
    chk("R5 wt write hit", int'(ft_wt), 2);
    chk("R5 wb no wt count", int'(lb_wt), 0);
    send(adr(4, 3), 1'b0, 1'b0, a, b);
    chk("R6 clean victim no wb", int'(lb_wb), 1);
    send(adr(5, 3), 1'b0, 1'b0, a, b);
    chk("R5 write-hit dirty evicted wb", int'(lb_wb), 2);
    chk("R7 de tracks", int'(lb_de), 2);
    chk("R7 ft de zero", int'(ft_de), 0);
  endtask

  task automatic t_prefetch();
    logic a, b;
    do_reset();
    send(adr(7, 1), 1'b0, 1'b1, a, b);
    send(adr(7, 1), 1'b0, 1'b1, a, b);
    send(adr(7, 1), 1'b0, 1'b0, a, b);
    chk("R8 pf miss", int'(lb_pm), 1);
    chk("R8 pf hit", int'(ft_ph), 1);
    chk("R8 dmd hit", int'(lb_dh), 1);
    chk("R8 dmd miss excl pf", int'(ft_dm), 0);
  endtask

  task automatic t_clear();
    logic a, b;
    do_reset();
    send(adr(9, 0), 1'b1, 1'b0, a, b);
    send(adr(9, 0), 1'b0, 1'b0, a, b);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R10 lb cleared", int'(lb_dh + lb_dm + lb_wt), 0);
    chk("R10 ft cleared", int'(ft_dh + ft_dm + ft_wt), 0);
    send(adr(9, 0), 1'b0, 1'b0, a, b);
    chk("R10 tags kept", int'(a & b), 1);
    send(adr(10, 0), 1'b0, 1'b0, a, b);
    send(adr(11, 0), 1'b0, 1'b0, a, b);
    chk("R10 dirty kept", int'(lb_wb), 1);
  endtask

  task automatic t_sat();
    logic a, b;
    do_reset();
    for (int i = 0; i < 260; i++) send(adr(3, 1), 1'b0, 1'b0, a, b);
    chk("R9 saturate lb", int'(lb_dh), 255);
    chk("R9 saturate ft", int'(ft_dh), 255);
    chk("R9 miss unaffected", int'(lb_dm), 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_sets();
    t_repl();
    t_write();
    t_prefetch();
    t_clear();
    t_sat();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(HALF * 2 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule